// File: doc/BRIEF.md
# Remote Terminal Illegal Command Filter

This block sits behind the command decoder of a serial-bus remote terminal. It screens each valid command word and decides whether the terminal should respond normally, respond with the message-error bit set, or stay silent. The decision comes from a host-loaded bitmap with one bit for every combination of broadcast form, transmit/receive direction, subaddress and word count. For the mode subaddresses, the word count field is a mode code.

Each command arrives as decoded fields qualified by a one-cycle strobe. One clock later the block gives a one-cycle verdict strobe and a verdict code. With that verdict come a message-error flag for the status word and a flag telling the receive path to drop the data words that follow. The host fills the bitmap through a simple 16-bit word write port. Two configuration enables let the terminal turn off illegal-command screening altogether, and stop recognising broadcast commands.

Top module: `rtif_cmd_filter`

## Requirements
- R1: Every cycle in which `cmd_vld` is high produces exactly one cycle with `dec_vld` high, on the following clock. `dec_vld` is low after every cycle in which `cmd_vld` was low.
- R2: The bitmap index is {broadcast, tr, subaddress[4:0], count[4:0]}, with broadcast as the most significant bit. The index selects word index[11:4] and bit index[3:0] of the bitmap. A set bit marks the command illegal and gives verdict code 2 (illegal). A clear bit gives code 1 (accept).
- R3: Subaddresses 0 and 31 are mode subaddresses. For these, the mode code in the low 5-bit field selects the bitmap entry, in the same way a word count does for other subaddresses.
- R4: While `illeg_en` is low, every command addressed to the terminal gets code 1 (accept), whatever the bitmap holds.
- R5: A command to address 31 is broadcast when `bcast_en` is high, and `dec_bcast` is then set with the verdict. When `bcast_en` is low, such a command gets code 0 (ignore), unless `own_rta` is 31.
- R6: The broadcast and non-broadcast forms of the same command use separate bitmap bits. Either form can be illegal while the other is legal.
- R7: A command whose address is neither `own_rta` nor a recognised broadcast gets code 0 (ignore). It raises neither `msg_err` nor `rx_discard`.
- R8: `msg_err` is high exactly with an illegal verdict. `rx_discard` is high exactly with an illegal verdict on a receive command (tr = 0).
- R9: A bitmap write in the same cycle as a command lookup takes effect after the lookup. That lookup sees the old contents, and the next lookup sees the new ones.
- R10: Reset clears the whole bitmap and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Valid command word strobe |
| cmd_rta | input | 5 | Terminal address field of the command |
| cmd_tr | input | 1 | Direction bit (1 = transmit) |
| cmd_sa | input | 5 | Subaddress field |
| cmd_wc | input | 5 | Word count or mode code field |
| own_rta | input | 5 | This terminal's address |
| illeg_en | input | 1 | Enable illegal-command screening |
| bcast_en | input | 1 | Enable broadcast recognition |
| map_we | input | 1 | Bitmap word write strobe |
| map_waddr | input | 8 | Bitmap word address |
| map_wdata | input | 16 | Bitmap word data |
| dec_vld | output | 1 | Verdict strobe |
| dec_code | output | 2 | Verdict: 0 ignore, 1 accept, 2 illegal |
| dec_bcast | output | 1 | Verdict concerns a broadcast command |
| msg_err | output | 1 | Set message-error bit in the status word |
| rx_discard | output | 1 | Drop the received data words |

## Verification
The bench builds the block with its default widths: 5-bit address, subaddress and count fields and 16-bit bitmap words. That gives the full 4096-entry bitmap in 256 words. With these values every mode subaddress and both broadcast forms can be reached, and a bitmap word shared by neighbouring entries can be written while a lookup reads it in the same cycle. The bench sets single bits in chosen words and then probes those entries and their neighbours, in both forms, with the enables on and off.

// File: rtl/rtif_pkg.sv
package rtif_pkg;
  typedef enum logic [1:0] {
    VERD_IGNORE  = 2'd0,
    VERD_ACCEPT  = 2'd1,
    VERD_ILLEGAL = 2'd2
  } verdict_e;
endpackage

// File: rtl/rtif_cmd_index.sv
// Address match and bitmap index construction (combinational).
module rtif_cmd_index #(
  parameter int RTA_W = 5,
  parameter int SA_W  = 5,
  parameter int WC_W  = 5,
  localparam int IDX_W = 2 + SA_W + WC_W
) (
  input  logic [RTA_W-1:0] cmd_rta,
  input  logic             cmd_tr,
  input  logic [SA_W-1:0]  cmd_sa,
  input  logic [WC_W-1:0]  cmd_wc,
  input  logic [RTA_W-1:0] own_rta,
  input  logic             bcast_en,
  output logic             is_mine,
  output logic             is_bcast,
  output logic [IDX_W-1:0] idx
);
  localparam logic [RTA_W-1:0] BCAST_RTA = '1;

  logic bcast_hit;
  logic own_hit;

  always_comb begin
    bcast_hit = bcast_en && (cmd_rta == BCAST_RTA);
    own_hit   = (cmd_rta == own_rta);
    is_bcast  = bcast_hit;
    is_mine   = bcast_hit || own_hit;
    // Mode subaddresses carry the mode code in the same low field, so the
    // index layout is uniform across all subaddresses.
    idx       = {bcast_hit, cmd_tr, cmd_sa, cmd_wc};
  end
endmodule

// File: rtl/rtif_illeg_map.sv
// Illegalization bitmap: word-written storage with a registered bit read.
module rtif_illeg_map #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 16,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int ADDR_W = IDX_W - BIT_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  wr_hit;

  logic [WORD_W-1:0] rd_word_q, rd_word_d;
  logic [BIT_W-1:0]  rd_sel_q, rd_sel_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wr_hit[i] = we && (waddr == ADDR_W'(i));
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_hit[g]) begin
        mem[g] <= wdata;
      end
    end
  end

  // The read samples the array before this edge's write lands, so a
  // colliding lookup sees the previous contents.
  always_comb begin
    rd_word_d = rd_word_q;
    rd_sel_d  = rd_sel_q;
    if (rd_en) begin
      rd_word_d = mem[rd_idx[IDX_W-1:BIT_W]];
      rd_sel_d  = rd_idx[BIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word_q <= '0;
      rd_sel_q  <= '0;
    end else begin
      rd_word_q <= rd_word_d;
      rd_sel_q  <= rd_sel_d;
    end
  end

  assign rd_bit = rd_word_q[rd_sel_q];
endmodule

// File: rtl/rtif_verdict.sv
// Pipeline stage aligned with the bitmap read; forms the verdict.
module rtif_verdict
  import rtif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic       is_mine,
  input  logic       is_bcast,
  input  logic       cmd_tr,
  input  logic       illeg_en,
  input  logic       map_bit,
  output logic       dec_vld,
  output logic [1:0] dec_code,
  output logic       dec_bcast,
  output logic       msg_err,
  output logic       rx_discard
);
  logic vld_q, mine_q, bcast_q, tr_q, en_q;
  logic mine_d, bcast_d, tr_d, en_d;
  verdict_e code;

  always_comb begin
    mine_d  = mine_q;
    bcast_d = bcast_q;
    tr_d    = tr_q;
    en_d    = en_q;
    if (cmd_vld) begin
      mine_d  = is_mine;
      bcast_d = is_bcast;
      tr_d    = cmd_tr;
      en_d    = illeg_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      mine_q  <= 1'b0;
      bcast_q <= 1'b0;
      tr_q    <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      vld_q   <= cmd_vld;
      mine_q  <= mine_d;
      bcast_q <= bcast_d;
      tr_q    <= tr_d;
      en_q    <= en_d;
    end
  end

  always_comb begin
    code = VERD_IGNORE;
    if (vld_q && mine_q) begin
      code = (en_q && map_bit) ? VERD_ILLEGAL : VERD_ACCEPT;
    end
  end

  assign dec_vld    = vld_q;
  assign dec_code   = code;
  assign dec_bcast  = vld_q && mine_q && bcast_q;
  assign msg_err    = (code == VERD_ILLEGAL);
  assign rx_discard = (code == VERD_ILLEGAL) && !tr_q;
endmodule

// File: rtl/rtif_cmd_filter.sv
module rtif_cmd_filter #(
  parameter int RTA_W  = 5,
  parameter int SA_W   = 5,
  parameter int WC_W   = 5,
  parameter int WORD_W = 16,
  localparam int IDX_W  = 2 + SA_W + WC_W,
  localparam int ADDR_W = IDX_W - $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [RTA_W-1:0]  cmd_rta,
  input  logic              cmd_tr,
  input  logic [SA_W-1:0]   cmd_sa,
  input  logic [WC_W-1:0]   cmd_wc,
  input  logic [RTA_W-1:0]  own_rta,
  input  logic              illeg_en,
  input  logic              bcast_en,
  input  logic              map_we,
  input  logic [ADDR_W-1:0] map_waddr,
  input  logic [WORD_W-1:0] map_wdata,
  output logic              dec_vld,
  output logic [1:0]        dec_code,
  output logic              dec_bcast,
  output logic              msg_err,
  output logic              rx_discard
);
  logic             is_mine;
  logic             is_bcast;
  logic [IDX_W-1:0] idx;
  logic             map_bit;

  rtif_cmd_index #(.RTA_W(RTA_W), .SA_W(SA_W), .WC_W(WC_W)) u_index (
    .cmd_rta (cmd_rta),
    .cmd_tr  (cmd_tr),
    .cmd_sa  (cmd_sa),
    .cmd_wc  (cmd_wc),
    .own_rta (own_rta),
    .bcast_en(bcast_en),
    .is_mine (is_mine),
    .is_bcast(is_bcast),
    .idx     (idx)
  );

  rtif_illeg_map #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (map_we),
    .waddr (map_waddr),
    .wdata (map_wdata),
    .rd_en (cmd_vld),
    .rd_idx(idx),
    .rd_bit(map_bit)
  );

  rtif_verdict u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld   (cmd_vld),
    .is_mine   (is_mine),
    .is_bcast  (is_bcast),
    .cmd_tr    (cmd_tr),
    .illeg_en  (illeg_en),
    .map_bit   (map_bit),
    .dec_vld   (dec_vld),
    .dec_code  (dec_code),
    .dec_bcast (dec_bcast),
    .msg_err   (msg_err),
    .rx_discard(rx_discard)
  );
endmodule

// File: rtl/rtif_cmd_filter_chk.sv
module rtif_cmd_filter_chk #(
  parameter int RTA_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [RTA_W-1:0] cmd_rta,
  input logic [RTA_W-1:0] own_rta,
  input logic             illeg_en,
  input logic             bcast_en,
  input logic             dec_vld,
  input logic [1:0]       dec_code,
  input logic             dec_bcast,
  input logic             msg_err,
  input logic             rx_discard
);
  localparam logic [RTA_W-1:0] BC = '1;

  a_r1_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> dec_vld);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !dec_vld);
  a_r4_bypass_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !illeg_en) |=> (dec_code != 2'd2));
  a_r5_bcast_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !bcast_en && cmd_rta == BC && own_rta != BC) |=> (dec_code == 2'd0));
  a_r5_bcast_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && bcast_en && cmd_rta == BC) |=> dec_bcast);
  a_r7_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_rta != own_rta && cmd_rta != BC) |=> (dec_code == 2'd0 && !msg_err));
  a_r8_err_with_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    msg_err |-> (dec_vld && dec_code == 2'd2));
  a_r8_discard_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_discard |-> msg_err);
endmodule

bind rtif_cmd_filter rtif_cmd_filter_chk #(.RTA_W(RTA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_vld   (cmd_vld),
  .cmd_rta   (cmd_rta),
  .own_rta   (own_rta),
  .illeg_en  (illeg_en),
  .bcast_en  (bcast_en),
  .dec_vld   (dec_vld),
  .dec_code  (dec_code),
  .dec_bcast (dec_bcast),
  .msg_err   (msg_err),
  .rx_discard(rx_discard)
);

// File: tb/sim_rtif_cmd_filter.sv
module sim_rtif_cmd_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_vld;
  logic [4:0]  cmd_rta;
  logic        cmd_tr;
  logic [4:0]  cmd_sa;
  logic [4:0]  cmd_wc;
  logic [4:0]  own_rta;
  logic        illeg_en;
  logic        bcast_en;
  logic        map_we;
  logic [7:0]  map_waddr;
  logic [15:0] map_wdata;
  logic        dec_vld;
  logic [1:0]  dec_code;
  logic        dec_bcast;
  logic        msg_err;
  logic        rx_discard;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] mdl [256];

  always #5 clk = ~clk;

  rtif_cmd_filter u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_rta(cmd_rta),
    .cmd_tr(cmd_tr), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .own_rta(own_rta),
    .illeg_en(illeg_en), .bcast_en(bcast_en), .map_we(map_we),
    .map_waddr(map_waddr), .map_wdata(map_wdata), .dec_vld(dec_vld),
    .dec_code(dec_code), .dec_bcast(dec_bcast), .msg_err(msg_err),
    .rx_discard(rx_discard)
  );

  // Expected {vld, code[1:0], bcast, msg_err, discard}
  function automatic logic [5:0] expect_out(bit v, int rta, bit tr, int sa, int wc);
    bit bc, mine, ill;
    int ix;
    logic [1:0] code;
    if (!v) return 6'b0;
    bc   = bcast_en && (rta == 31);
    mine = bc || (rta == own_rta);
    ix   = (bc ? 2048 : 0) + (tr ? 1024 : 0) + sa * 32 + wc;
    ill  = illeg_en && mine && mdl[ix / 16][ix % 16];
    code = !mine ? 2'd0 : (ill ? 2'd2 : 2'd1);
    return {1'b1, code, mine && bc, ill, ill && !tr};
  endfunction

  task automatic compare(string tag, logic [5:0] exp);
    logic [5:0] act;
    act = {dec_vld, dec_code, dec_bcast, msg_err, rx_discard};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, int rta, bit tr, int sa, int wc,
                      bit we, int wa, logic [15:0] wd);
    logic [5:0] exp;
    @(negedge clk);
    cmd_vld = v; cmd_rta = 5'(rta); cmd_tr = tr; cmd_sa = 5'(sa); cmd_wc = 5'(wc);
    map_we = we; map_waddr = 8'(wa); map_wdata = wd;
    exp = expect_out(v, rta, tr, sa, wc);
    @(posedge clk);
    if (we) mdl[wa] = wd;
    #3;
    compare(tag, exp);
  endtask

  task automatic cmd(string tag, int rta, bit tr, int sa, int wc);
    step(tag, 1'b1, rta, tr, sa, wc, 1'b0, 0, 16'h0);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 16'h0);
  endtask

  task automatic set_illegal(bit bc, bit tr, int sa, int wc);
    int ix;
    ix = (bc ? 2048 : 0) + (tr ? 1024 : 0) + sa * 32 + wc;
    step("R2", 1'b0, 0, 1'b0, 0, 0, 1'b1, ix / 16, mdl[ix / 16] | 16'(1 << (ix % 16)));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 16'h0;
    rst_n = 1'b0; cmd_vld = 0; cmd_rta = 0; cmd_tr = 0; cmd_sa = 0; cmd_wc = 0;
    own_rta = 5'd5; illeg_en = 1'b1; bcast_en = 1'b1;
    map_we = 0; map_waddr = 0; map_wdata = 0;
    repeat (3) @(posedge clk);
    #3;
    compare("R10", 6'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: cleared bitmap accepts everything
    cmd("R10", 5, 0, 3, 5);
    cmd("R10", 31, 1, 17, 31);

    // R2 / R8: receive command marked illegal, neighbours stay legal
    set_illegal(0, 0, 3, 5);
    cmd("R2", 5, 0, 3, 5);
    cmd("R2", 5, 0, 3, 6);
    cmd("R2", 5, 0, 3, 4);
    cmd("R8", 5, 0, 3, 5);
    // R8: transmit illegal gives error without discard
    set_illegal(0, 1, 7, 2);
    cmd("R8", 5, 1, 7, 2);
    cmd("R8", 5, 0, 7, 2);

    // R6: broadcast and non-broadcast forms independent
    cmd("R6", 31, 0, 3, 5);
    set_illegal(1, 0, 9, 1);
    cmd("R6", 31, 0, 9, 1);
    cmd("R6", 5, 0, 9, 1);

    // R5: broadcast recognition off
    bcast_en = 1'b0;
    cmd("R5", 31, 0, 9, 1);
    cmd("R5", 31, 0, 3, 5);
    own_rta = 5'd31;
    cmd("R5", 31, 0, 9, 1);
    own_rta = 5'd5;
    bcast_en = 1'b1;
    cmd("R5", 31, 0, 9, 1);

    // R7: other terminal's commands ignored even when entry is illegal
    cmd("R7", 6, 0, 3, 5);
    cmd("R7", 30, 1, 7, 2);

    // R3: mode subaddresses use mode code field
    set_illegal(0, 0, 0, 2);
    set_illegal(0, 1, 31, 18);
    cmd("R3", 5, 0, 0, 2);
    cmd("R3", 5, 0, 0, 3);
    cmd("R3", 5, 1, 31, 18);
    cmd("R3", 5, 1, 0, 18);

    // R4: screening disabled
    illeg_en = 1'b0;
    cmd("R4", 5, 0, 3, 5);
    cmd("R4", 31, 0, 9, 1);
    cmd("R4", 5, 1, 31, 18);
    illeg_en = 1'b1;

    // R9: write colliding with lookup of the same word
    begin
      int ix;
      ix = 12 * 32 + 4;
      step("R9", 1'b1, 5, 1'b0, 12, 4, 1'b1, ix / 16, mdl[ix / 16] | 16'(1 << (ix % 16)));
    end
    cmd("R9", 5, 0, 12, 4);

    // R1: back-to-back commands then idle cycles
    cmd("R1", 5, 0, 3, 5);
    cmd("R1", 5, 0, 3, 6);
    cmd("R1", 6, 0, 3, 6);
    idle("R1");
    idle("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule